// File: doc/BRIEF.md
# Read Beat Admission Throttle

This block sits on an AXI read path between a master and the downstream read port. Read data returning on R is written into a receive data FIFO that the block does not own. The block takes that FIFO's current fill level as an input and admits an AR request only when the beats still owed by the slave, the beats already sitting in the FIFO, and the new burst together fit within the FIFO depth. The R channel toward the FIFO therefore never needs back-pressure from a full buffer.

Admission is tracked with a single owed-beat counter. An AR handshake adds the burst length in beats, and every R handshake removes one. The R channel and the AR payload pass through untouched; only the AR valid and ready strobes are gated. A parameter selects between a live comparison, which allows back-to-back AR handshakes at the cost of a longer combinational path, and a registered comparison, which is shorter but leaves one idle cycle after each AR handshake.

The fill level is assumed to rise on the same clock edge as the R beat that is written into the FIFO. A beat in flight then moves from "owed" to "stored" without ever being counted twice or not at all.

Top module: `rd_beat_throttle`

## Requirements
- R1: While `rst` is high, `dn_ar_valid` and `up_ar_ready` are low. The first cycle after reset starts with an owed count of zero and no blocked cycle pending.
- R2: A request with length field `L` is counted as `L + 1` beats.
- R3: With `FULL_AR_RATE = 1`, a request is admitted in a cycle exactly when owed + `fifo_level` + beats <= `FIFO_DEPTH`, using that cycle's owed count and level.
- R4: With `FULL_AR_RATE = 0`, a request is admitted when no AR handshake happened in the previous cycle and (owed + `fifo_level` from the previous cycle) + beats <= `FIFO_DEPTH`.
- R5: On each clock edge the owed count grows by the beats of an AR handshake and shrinks by one for an R handshake. When both occur in the same cycle, both changes are applied.
- R6: `dn_ar_addr`, `dn_ar_id` and `dn_ar_len` equal their upstream counterparts. `dn_ar_valid` is `up_ar_valid` AND admitted, and `up_ar_ready` is `dn_ar_ready` AND admitted.
- R7: `up_r_valid`, `up_r_data`, `up_r_id`, `up_r_resp` and `up_r_last` equal their downstream counterparts in the same cycle. `dn_r_ready` equals `up_r_ready`, and an R beat counts when `dn_r_valid` and `up_r_ready` are both high.
- R8: If the fill level only rises through R beats, owed + `fifo_level` never exceeds `FIFO_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | LVL_W | Current fill level of the receive data FIFO |
| up_ar_valid | input | 1 | Read request valid from the master |
| up_ar_ready | output | 1 | Read request accepted by the throttle |
| up_ar_addr | input | ADDR_W | Request address |
| up_ar_id | input | ID_W | Request ID |
| up_ar_len | input | LEN_W | Burst length minus one |
| dn_ar_valid | output | 1 | Admitted request valid toward the slave |
| dn_ar_ready | input | 1 | Slave accepts request |
| dn_ar_addr | output | ADDR_W | Forwarded address |
| dn_ar_id | output | ID_W | Forwarded ID |
| dn_ar_len | output | LEN_W | Forwarded burst length minus one |
| dn_r_valid | input | 1 | Read beat valid from the slave |
| dn_r_ready | output | 1 | Read beat ready toward the slave |
| dn_r_data | input | DATA_W | Read data from the slave |
| dn_r_id | input | ID_W | Read ID from the slave |
| dn_r_resp | input | 2 | Read response from the slave |
| dn_r_last | input | 1 | Last beat of a burst from the slave |
| up_r_valid | output | 1 | Read beat valid toward the FIFO |
| up_r_ready | input | 1 | FIFO accepts read beat |
| up_r_data | output | DATA_W | Read data toward the FIFO |
| up_r_id | output | ID_W | Read ID toward the FIFO |
| up_r_resp | output | 2 | Read response toward the FIFO |
| up_r_last | output | 1 | Last beat toward the FIFO |

## Verification
An AR handshake and an R handshake can fall in the same cycle, so the owed count gains a burst and loses a beat on one edge. A random slave returns beats whenever some are owed, while the master keeps requests pending, so such cycles are frequent. A behavioural model then predicts the admission decision of the following cycles from its own integer count. In the slow-drain phase the FIFO level is pushed against the depth limit. A wrong net update there shows up as an admission one cycle too early or too late.

// File: rtl/rthr_pkg.sv
package rthr_pkg;

  // How the admission comparison is timed.
  typedef enum logic {
    ADMIT_REGISTERED = 1'b0,  // compare on last cycle's totals, one gap cycle per grant
    ADMIT_LIVE       = 1'b1   // compare on this cycle's totals, back-to-back grants
  } admit_mode_e;

endpackage

// File: rtl/rthr_owed_counter.sv
module rthr_owed_counter #(
  parameter int CNT_W = 11,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  input  logic [LEN_W-1:0] grant_len,
  input  logic             beat,
  output logic [CNT_W-1:0] owed
);

  logic [CNT_W-1:0] owed_q;
  logic [CNT_W-1:0] add_beats;
  logic [CNT_W-1:0] sub_beats;

  // A grant owes len+1 beats; a received beat settles one.
  assign add_beats = grant ? (CNT_W'(grant_len) + CNT_W'(1)) : '0;
  assign sub_beats = CNT_W'(beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else begin
      owed_q <= owed_q + add_beats - sub_beats;
    end
  end

  assign owed = owed_q;

endmodule

// File: rtl/rthr_admit_gate.sv
module rthr_admit_gate
  import rthr_pkg::*;
#(
  parameter int          FIFO_DEPTH = 1024,
  parameter int          CNT_W      = 11,
  parameter int          LEN_W      = 8,
  parameter admit_mode_e MODE       = ADMIT_REGISTERED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] owed,
  input  logic [CNT_W-1:0] level,
  input  logic [LEN_W-1:0] req_len,
  input  logic             granted,
  output logic             admit
);

  localparam int             SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(FIFO_DEPTH);

  logic [SUM_W-1:0] req_beats;
  logic [SUM_W-1:0] held_now;

  assign req_beats = SUM_W'(req_len) + SUM_W'(1);
  assign held_now  = SUM_W'(owed) + SUM_W'(level);

  generate
    if (MODE == ADMIT_LIVE) begin : g_live
      logic unused_live;
      assign unused_live = ^{clk, granted};
      assign admit = !rst && ((held_now + req_beats) <= LIMIT);
    end else begin : g_registered
      logic [SUM_W-1:0] held_q;
      logic             gap_q;

      // Beats in flight only move from owed to level, and FIFO reads only
      // lower the level, so last cycle's total is an upper bound unless a
      // grant was made; that cycle is skipped.
      always_ff @(posedge clk) begin
        if (rst) begin
          held_q <= '0;
          gap_q  <= 1'b0;
        end else begin
          held_q <= held_now;
          gap_q  <= granted;
        end
      end

      assign admit = !rst && !gap_q && ((held_q + req_beats) <= LIMIT);
    end
  endgenerate

endmodule

// File: rtl/rd_beat_throttle.sv
module rd_beat_throttle
  import rthr_pkg::*;
#(
  parameter int FIFO_DEPTH   = 1024,
  parameter int MAX_BURST    = 256,
  parameter int ID_W         = 6,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter bit FULL_AR_RATE = 1'b0,
  parameter int LVL_W        = $clog2(FIFO_DEPTH + 1),
  parameter int LEN_W        = $clog2(MAX_BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              up_ar_valid,
  output logic              up_ar_ready,
  input  logic [ADDR_W-1:0] up_ar_addr,
  input  logic [ID_W-1:0]   up_ar_id,
  input  logic [LEN_W-1:0]  up_ar_len,
  output logic              dn_ar_valid,
  input  logic              dn_ar_ready,
  output logic [ADDR_W-1:0] dn_ar_addr,
  output logic [ID_W-1:0]   dn_ar_id,
  output logic [LEN_W-1:0]  dn_ar_len,
  input  logic              dn_r_valid,
  output logic              dn_r_ready,
  input  logic [DATA_W-1:0] dn_r_data,
  input  logic [ID_W-1:0]   dn_r_id,
  input  logic [1:0]        dn_r_resp,
  input  logic              dn_r_last,
  output logic              up_r_valid,
  input  logic              up_r_ready,
  output logic [DATA_W-1:0] up_r_data,
  output logic [ID_W-1:0]   up_r_id,
  output logic [1:0]        up_r_resp,
  output logic              up_r_last
);

  localparam admit_mode_e MODE = FULL_AR_RATE ? ADMIT_LIVE : ADMIT_REGISTERED;

  logic [LVL_W-1:0] owed_q;
  logic             admit;
  logic             ar_fire;
  logic             r_fire;

  // AR path: payload straight through, strobes gated by admission.
  assign dn_ar_valid = up_ar_valid && admit;
  assign up_ar_ready = dn_ar_ready && admit;
  assign dn_ar_addr  = up_ar_addr;
  assign dn_ar_id    = up_ar_id;
  assign dn_ar_len   = up_ar_len;
  assign ar_fire     = up_ar_valid && dn_ar_ready && admit;

  // R path: untouched, ready comes from the FIFO side.
  assign up_r_valid = dn_r_valid;
  assign up_r_data  = dn_r_data;
  assign up_r_id    = dn_r_id;
  assign up_r_resp  = dn_r_resp;
  assign up_r_last  = dn_r_last;
  assign dn_r_ready = up_r_ready;
  assign r_fire     = dn_r_valid && up_r_ready;

  rthr_owed_counter #(
    .CNT_W (LVL_W),
    .LEN_W (LEN_W)
  ) u_owed (
    .clk       (clk),
    .rst       (rst),
    .grant     (ar_fire),
    .grant_len (up_ar_len),
    .beat      (r_fire),
    .owed      (owed_q)
  );

  rthr_admit_gate #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (LVL_W),
    .LEN_W      (LEN_W),
    .MODE       (MODE)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .owed    (owed_q),
    .level   (fifo_level),
    .req_len (up_ar_len),
    .granted (ar_fire),
    .admit   (admit)
  );

endmodule

// File: rtl/rd_beat_throttle_chk.sv
module rd_beat_throttle_chk #(
  parameter int FIFO_DEPTH   = 1024,
  parameter int LVL_W        = 11,
  parameter int LEN_W        = 8,
  parameter bit FULL_AR_RATE = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fifo_level,
  input logic             up_ar_valid,
  input logic             up_ar_ready,
  input logic             dn_ar_valid,
  input logic             dn_ar_ready,
  input logic [LEN_W-1:0] dn_ar_len,
  input logic             dn_r_valid,
  input logic             dn_r_ready,
  input logic [LVL_W-1:0] owed
);

  localparam int SH_W = LVL_W + 2;

  logic [SH_W-1:0] shadow_q;
  logic            ar_hs;
  logic            r_hs;

  assign ar_hs = dn_ar_valid && dn_ar_ready;
  assign r_hs  = dn_r_valid && dn_r_ready;

  // Independent beat ledger kept from the downstream handshakes only.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_q
                + (ar_hs ? (SH_W'(dn_ar_len) + SH_W'(1)) : SH_W'(0))
                - SH_W'(r_hs);
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!dn_ar_valid && !up_ar_ready));

  a_r5_count_tracks: assert property (@(posedge clk) disable iff (rst)
    SH_W'(owed) == shadow_q);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (shadow_q + SH_W'(fifo_level)) <= SH_W'(FIFO_DEPTH));

  a_r6_needs_request: assert property (@(posedge clk) disable iff (rst)
    dn_ar_valid |-> up_ar_valid);

  generate
    if (!FULL_AR_RATE) begin : g_reg_checks
      a_r4_gap_after_grant: assert property (@(posedge clk) disable iff (rst)
        ar_hs |=> !dn_ar_valid && !up_ar_ready);
    end
  endgenerate

endmodule

bind rd_beat_throttle rd_beat_throttle_chk #(
  .FIFO_DEPTH   (FIFO_DEPTH),
  .LVL_W        (LVL_W),
  .LEN_W        (LEN_W),
  .FULL_AR_RATE (FULL_AR_RATE)
) u_rd_beat_throttle_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_level  (fifo_level),
  .up_ar_valid (up_ar_valid),
  .up_ar_ready (up_ar_ready),
  .dn_ar_valid (dn_ar_valid),
  .dn_ar_ready (dn_ar_ready),
  .dn_ar_len   (dn_ar_len),
  .dn_r_valid  (dn_r_valid),
  .dn_r_ready  (dn_r_ready),
  .owed        (owed_q)
);

// File: tb/test_rd_beat_throttle.sv
module throttle_env #(
  parameter bit FULL = 1'b0
) (
  input logic clk
);
  localparam int D     = 16;
  localparam int MB    = 8;
  localparam int IDW   = 4;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int CW    = $clog2(D + 1);
  localparam int LW    = $clog2(MB);
  localparam int NCYC  = 4000;

  logic          rst;
  logic [CW-1:0] fifo_level;
  logic          up_ar_valid, up_ar_ready, dn_ar_valid, dn_ar_ready;
  logic [AW-1:0] up_ar_addr, dn_ar_addr;
  logic [IDW-1:0] up_ar_id, dn_ar_id, dn_r_id, up_r_id;
  logic [LW-1:0] up_ar_len, dn_ar_len;
  logic          dn_r_valid, dn_r_ready, dn_r_last, up_r_valid, up_r_ready, up_r_last;
  logic [DW-1:0] dn_r_data, up_r_data;
  logic [1:0]    dn_r_resp, up_r_resp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state.
  int owed, held_prev, level, pend;
  bit gap;
  bit pop;

  rd_beat_throttle #(
    .FIFO_DEPTH (D), .MAX_BURST (MB), .ID_W (IDW), .ADDR_W (AW),
    .DATA_W (DW), .FULL_AR_RATE (FULL)
  ) i_rd_beat_throttle (
    .clk (clk), .rst (rst), .fifo_level (fifo_level),
    .up_ar_valid (up_ar_valid), .up_ar_ready (up_ar_ready),
    .up_ar_addr (up_ar_addr), .up_ar_id (up_ar_id), .up_ar_len (up_ar_len),
    .dn_ar_valid (dn_ar_valid), .dn_ar_ready (dn_ar_ready),
    .dn_ar_addr (dn_ar_addr), .dn_ar_id (dn_ar_id), .dn_ar_len (dn_ar_len),
    .dn_r_valid (dn_r_valid), .dn_r_ready (dn_r_ready), .dn_r_data (dn_r_data),
    .dn_r_id (dn_r_id), .dn_r_resp (dn_r_resp), .dn_r_last (dn_r_last),
    .up_r_valid (up_r_valid), .up_r_ready (up_r_ready), .up_r_data (up_r_data),
    .up_r_id (up_r_id), .up_r_resp (up_r_resp), .up_r_last (up_r_last)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d t=%0t actual=%0h expected=%0h", req, FULL, $time, act, exp);
    end
  endtask

  task automatic drive(input int cyc);
    bit directed;
    directed = (cyc < 4);
    up_ar_valid = directed ? 1'b1 : ($urandom_range(3, 0) != 0);
    up_ar_len   = directed ? LW'(MB - 1) : LW'($urandom_range(MB - 1, 0));
    up_ar_addr  = AW'($urandom);
    up_ar_id    = IDW'($urandom);
    dn_ar_ready = directed ? 1'b1 : ($urandom_range(3, 0) != 0);
    dn_r_valid  = !directed && (pend > 0) && ($urandom_range(4, 0) != 0);
    dn_r_data   = DW'($urandom);
    dn_r_id     = IDW'($urandom);
    dn_r_resp   = 2'($urandom);
    dn_r_last   = 1'($urandom);
    up_r_ready  = (cyc < 2000) ? 1'b1 : ($urandom_range(7, 0) != 0);
    fifo_level  = CW'(level);
    if (directed) pop = 1'b0;
    else if (cyc < 1500) pop = (level > 0) && ($urandom_range(7, 0) == 0);
    else pop = (level > 0) && ($urandom_range(1, 0) == 0);
  endtask

  task automatic compare_and_step();
    int  beats;
    bit  fits, ar_hs, r_hs;
    beats = int'(up_ar_len) + 1;                                  // R2
    if (FULL) fits = (owed + level + beats) <= D;                 // R3
    else      fits = !gap && ((held_prev + beats) <= D);          // R4
    chk(FULL ? "R3 R2 R5 dn_ar_valid" : "R4 R2 R5 dn_ar_valid",
        64'(dn_ar_valid), 64'(up_ar_valid && fits));
    chk("R6 up_ar_ready", 64'(up_ar_ready), 64'(dn_ar_ready && fits));
    chk("R6 ar payload", 64'({dn_ar_addr, dn_ar_id, dn_ar_len}),
        64'({up_ar_addr, up_ar_id, up_ar_len}));
    chk("R7 r passthrough",
        64'({up_r_valid, up_r_data, up_r_id, up_r_resp, up_r_last, dn_r_ready}),
        64'({dn_r_valid, dn_r_data, dn_r_id, dn_r_resp, dn_r_last, up_r_ready}));
    ar_hs = up_ar_valid && dn_ar_ready && fits;
    r_hs  = dn_r_valid && up_r_ready;
    held_prev = owed + level;
    gap   = ar_hs;
    owed  = owed + (ar_hs ? beats : 0) - (r_hs ? 1 : 0);          // R5
    pend  = pend + (ar_hs ? beats : 0) - (r_hs ? 1 : 0);
    level = level + (r_hs ? 1 : 0) - (pop ? 1 : 0);
    if (owed + level > D) begin                                   // R8
      chk("R8 owed+level bound", 64'(owed + level), 64'(D));
    end
  endtask

  initial begin
    rst = 1'b1;
    owed = 0; held_prev = 0; level = 0; pend = 0; gap = 0; pop = 0;
    fifo_level = '0;
    up_ar_valid = 1'b1; dn_ar_ready = 1'b1;
    up_ar_addr = '0; up_ar_id = '0; up_ar_len = '0;
    dn_r_valid = 1'b0; dn_r_data = '0; dn_r_id = '0; dn_r_resp = '0; dn_r_last = 1'b0;
    up_r_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 quiet in reset", 64'({dn_ar_valid, up_ar_ready}), 64'(0));
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      drive(cyc);
      #1;
      compare_and_step();
      @(negedge clk);
    end
    done = 1'b1;
  end
endmodule

module test_rd_beat_throttle;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  throttle_env #(.FULL(1'b1)) env_live (.clk(clk));
  throttle_env #(.FULL(1'b0)) env_reg  (.clk(clk));

  initial begin
    int n;
    int wd_fail;
    n = 0;
    wd_fail = 0;
    while (!(env_live.done && env_reg.done) && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!(env_live.done && env_reg.done)) begin
      wd_fail = 1;
      $display("FAIL watchdog R1..all actual=running expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             env_live.checks + env_reg.checks + wd_fail,
             env_live.fails + env_reg.fails + wd_fail);
    $finish;
  end
endmodule